// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a read or write burst inside a synchronous DRAM. A column command loads a starting column, a burst length code and an ordering choice. From the next clock on, the block presents one column per cycle, together with a valid flag and a flag that marks the final beat. Fixed-length bursts stay inside the aligned block of columns that holds the starting column. A full-page burst walks the entire row and wraps around until it is stopped.

A burst-stop or precharge input ends the burst at once. A new column command may arrive on any cycle. It discards the running burst and starts a fresh one from the new column, so the controller can change columns at random on every clock.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, and after it is released with no command, `beat_valid` and `last_beat` are 0 and `col_out` is 0. Whenever no burst is active, `col_out` is 0.
- R2: `blen_sel` is taken when `start` is high. Code 0 gives a length of 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page. Codes 4, 5 and 6 behave as length 1. A fixed burst raises `beat_valid` for exactly that many cycles, starting in the cycle after `start`.
- R3: Sequential order (`interleave`=0, fixed length BL): the low log2(BL) bits of beat k are (start low bits + k) mod BL. The upper bits equal those of the starting column.
- R4: Interleaved order (`interleave`=1, fixed length BL): the low log2(BL) bits of beat k are the start low bits XOR k. The upper bits equal those of the starting column.
- R5: A full-page burst always runs in sequential order, whatever `interleave` is. Each beat's column is one more than the previous beat's column, and column 511 is followed by 0. The burst continues until it is terminated or restarted.
- R6: `last_beat` is high only on the final beat of a fixed-length burst. It is never high in full-page mode. If no `start` comes in that cycle, `beat_valid` is 0 in the following cycle.
- R7: If `burst_stop` or `precharge` is high at a clock edge and `start` is low, `beat_valid` is 0 from the next cycle.
- R8: `start` is accepted in any cycle, including during a burst and together with `burst_stop` or `precharge`. In the next cycle, beat 0 of the new burst shows `start_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Column command: load a new burst |
| start_col | input | 9 | Starting column |
| blen_sel | input | 3 | Burst length code |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| burst_stop | input | 1 | Burst-stop command |
| precharge | input | 1 | Precharge command (also ends the burst) |
| beat_valid | output | 1 | A burst beat is presented this cycle |
| col_out | output | 9 | Column of the current beat |
| last_beat | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach from the ports is the full-page wrap from column 511 to 0. It needs a start near the top of the row followed by a long run with no commands. The stimulus starts a full-page burst at column 505 with `interleave` set, lets it run for several hundred beats across the wrap, and then stops it with a precharge. Further directed cases cover every length and order from unaligned starting columns, as well as restarts issued mid-burst and together with a stop. A stretch of random commands follows, compared cycle by cycle against a behavioural model.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_sel,
  input  logic             interleave,
  input  logic             burst_stop,
  input  logic             precharge,
  output logic             beat_valid,
  output logic [COL_W-1:0] col_out,
  output logic             last_beat
);
  localparam logic [COL_W-1:0] ALL1 = {COL_W{1'b1}};

  logic             act, fp, il;
  logic [COL_W-1:0] base, cnt, mask;
  logic [COL_W-1:0] mask_in;

  always_comb begin
    case (blen_sel)
      3'd1:    mask_in = COL_W'(1);
      3'd2:    mask_in = COL_W'(3);
      3'd3:    mask_in = COL_W'(7);
      3'd7:    mask_in = ALL1;
      default: mask_in = '0;
    endcase
  end

  wire at_end = act && !fp && (cnt == mask);
  wire [COL_W-1:0] low = il ? ((base ^ cnt) & mask) : ((base + cnt) & mask);

  assign beat_valid = act;
  assign last_beat  = at_end;
  assign col_out    = act ? ((base & ~mask) | low) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0; fp <= 1'b0; il <= 1'b0;
      base <= '0; cnt <= '0; mask <= '0;
    end else if (start) begin
      act  <= 1'b1;
      fp   <= (blen_sel == 3'd7);
      il   <= interleave && (blen_sel != 3'd7);
      base <= start_col;
      mask <= mask_in;
      cnt  <= '0;
    end else if (burst_stop || precharge || at_end) begin
      act <= 1'b0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (col_out == '0 && !last_beat));

  assert_start_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_out == $past(start_col)));

  assert_term_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (burst_stop || precharge)) |=> !beat_valid);

  assert_last_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !beat_valid);

  assert_fullpage_no_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && blen_sel == 3'd7) |=> !last_beat);

  assert_fullpage_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat && !start && !burst_stop && !precharge && fp)
      |=> (beat_valid && col_out == $past(col_out) + 1'b1));

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int PAGE = 1 << W;

  logic clk = 0, rst_n = 0;
  logic start = 0, interleave = 0, burst_stop = 0, precharge = 0;
  logic [W-1:0] start_col = '0;
  logic [2:0] blen_sel = '0;
  logic beat_valid, last_beat;
  logic [W-1:0] col_out;

  int checks = 0, fails = 0;
  bit m_act = 0, m_il = 0;
  int m_base = 0, m_cnt = 0, m_len = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .blen_sel(blen_sel), .interleave(interleave), .burst_stop(burst_stop),
    .precharge(precharge), .beat_valid(beat_valid), .col_out(col_out),
    .last_beat(last_beat));

  function automatic int len_of(input logic [2:0] s);
    case (s)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col();
    int blk, low;
    if (!m_act) return 0;
    if (m_len == 0) return (m_base + m_cnt) % PAGE;
    blk = m_len;
    if (m_il) low = (m_base % blk) ^ m_cnt;
    else low = ((m_base % blk) + m_cnt) % blk;
    return m_base - (m_base % blk) + low;
  endfunction

  function automatic bit exp_last();
    return m_act && m_len != 0 && m_cnt == m_len - 1;
  endfunction

  task automatic check(input string tag);
    int ec; bit el;
    ec = exp_col(); el = exp_last();
    checks++;
    if (beat_valid !== m_act || col_out !== W'(ec) || last_beat !== el) begin
      fails++;
      $display("FAIL %s: valid/col/last = %0b/%0d/%0b expected %0b/%0d/%0b",
               tag, beat_valid, col_out, last_beat, m_act, ec, el);
    end
  endtask

  task automatic step(input bit s, input int c, input logic [2:0] bl,
                      input bit il, input bit bs, input bit pc, input string tag);
    start = s; start_col = W'(c); blen_sel = bl; interleave = il;
    burst_stop = bs; precharge = pc;
    @(posedge clk);
    if (s) begin
      m_act = 1; m_base = c; m_cnt = 0; m_len = len_of(bl);
      m_il = il && (m_len != 0);
    end else if (bs || pc || exp_last()) m_act = 0;
    else if (m_act) m_cnt = (m_cnt + 1) % PAGE;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3'd0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 400000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    idle(2, "R1 idle");
    for (int b = 0; b < 7; b++) begin
      step(1, 9'h0b5 + b * 37, 3'(b), 0, 0, 0, "R2 R3 sequential");
      idle(9, "R2 R6 length end");
      step(1, 9'h1f5 - b * 11, 3'(b), 1, 0, 0, "R2 R4 interleaved");
      idle(9, "R2 R6 length end");
    end
    step(1, 505, 3'd7, 1, 0, 0, "R5 full page");
    idle(600, "R5 wrap");
    step(0, 0, 3'd0, 0, 0, 1, "R7 precharge");
    idle(2, "R7 idle");
    step(1, 100, 3'd3, 0, 0, 0, "R8 start");
    idle(2, "R3 run");
    step(0, 0, 3'd0, 0, 1, 0, "R7 burst stop");
    idle(2, "R7 idle");
    step(1, 20, 3'd3, 1, 0, 0, "R8 start");
    idle(3, "R4 run");
    step(1, 301, 3'd2, 0, 0, 0, "R8 restart");
    step(1, 77, 3'd1, 1, 1, 1, "R8 start beats stop");
    idle(4, "R6 end");
    for (int i = 0; i < 4000; i++)
      step(($urandom % 5) == 0, $urandom % PAGE, 3'($urandom % 8), $urandom % 2,
           ($urandom % 23) == 0, ($urandom % 29) == 0, "R2 R3 R4 R5 R6 R7 R8 random");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule